// File: doc/BRIEF.md
# Watchdog Timer

A watchdog timer that software reaches through two 32-bit registers on a simple synchronous bus. A control word holds a run bit, an expiry action bit, a sticky fired flag and a read-only disabled flag, and accepts a trigger bit. A count word holds the reload value on a write and returns the time left on a read. A prescaler divides the system clock into ticks, nominally one second each. The down-counter loses one unit per tick while the timer runs.

Software programs the reload value and then arms the timer. From then on it must refresh the timer with a trigger write before the count runs out. Arming and refreshing are separate acts. Setting the run bit on a stopped timer resumes the count it holds and ignores a trigger in the same write. Only a trigger written while the timer is already running reloads the counter. When the counter reaches zero, the block gives a one-cycle request on either the system-reset output or the power-off output, as the action bit selects. It also sets the fired flag.

The fired flag and the action bit are cleared only by the power-on reset. They keep their values through the system reset that the block itself requests, so software can tell after reboot that the watchdog caused it. An external enable input can disable the hardware entirely. While it is disabled, the timer never runs and never fires.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, the control word reads 0x4 when enabled (run 0, fired 0, action 1, disabled 0), the count word reads 0xFFFF, and both request outputs are low.
- R2: The control word is at byte offset 0x0 and the count word at 0x4. Any other offset reads 0 and ignores writes. Read data appears in the cycle after the read strobe and holds until the next read. Control bits: 0 run, 1 fired (write 1 to clear), 2 action (1 reset, 0 power-off), 3 disabled (read-only), 4 trigger (write-only, reads 0).
- R3: Writing run=1 to a stopped, enabled timer starts it and restarts the prescaler. The counter resumes from its held value, or loads the reload value if it holds 0.
- R4: A trigger bit in the same write that starts the timer does not reload the counter.
- R5: A control write with run=1 and trigger=1 while the timer is running reloads the counter from the reload value and restarts the prescaler.
- R6: Writing run=0 halts the timer, and the counter then holds its value.
- R7: Writing the count word sets the reload value from its low 16 bits, with 0 stored as 1. Reading the count word returns the remaining count, not the reload value.
- R8: While the timer runs, the counter drops by one every TICK_DIV clock cycles, counted from the last start or reload.
- R9: When the counter steps from 1 to 0, the counter holds 0, run clears, fired sets, and exactly one cycle of request appears on the reset output if action is 1 or on the power-off output if action is 0. The request appears in the cycle after the last tick.
- R10: The fired flag and the action bit keep their values through the system reset. The fired flag clears on a write of 1 to bit 1, and both return to their reset values on power-on reset.
- R11: The system reset clears run and sets the counter and the reload value to 0xFFFF.
- R12: While the enable input is low, bit 3 reads 1, run is cleared within one cycle and cannot be set, and no tick, expiry or request occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porRstN | input | 1 | Power-on reset, active low, clears everything |
| sysRstN | input | 1 | System reset, active low, spares fired and action |
| hwEnable | input | 1 | External watchdog enable; low disables the hardware |
| busAddr | input | ADDR_W | Byte offset of the register accessed |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Registered read data |
| rstReq | output | 1 | One-cycle system-reset request on expiry |
| pwrOffReq | output | 1 | One-cycle power-off request on expiry |

## Verification
The bench builds the block with TICK_DIV set to 4 and the other parameters at their defaults. With that divider, a reload of one or two ticks expires within eight cycles, so the exact cycle of each request pulse can be checked against a hand count. The short divider also makes a 1-to-0 expiry, a start from a zero count, and a decrement after a resumed start happen many times in a short run. A behavioural model runs beside the block and checks read data and both request outputs on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int RUN_BIT   = 0;
  localparam int FIRED_BIT = 1;
  localparam int ACT_BIT   = 2;
  localparam int DIS_BIT   = 3;
  localparam int TRIG_BIT  = 4;

  typedef struct packed {
    logic start;
    logic refresh;
    logic stop;
    logic cntWr;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int COUNT_W  = 16,
  parameter int TICK_DIV = 125_000_000
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRstN,
  input  logic               hwEnable,
  input  logic               runQ,
  input  wdStrobe_t          strb,
  input  logic [COUNT_W-1:0] wrVal,
  output logic [COUNT_W-1:0] cntVal,
  output logic               expire
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;
  localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

  logic anyRstN;
  logic running;
  logic tick;
  logic [COUNT_W-1:0] cntQ;
  logic [COUNT_W-1:0] reloadQ;

  assign anyRstN = porRstN & sysRstN;
  assign running = runQ & hwEnable;

  generate
    if (TICK_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] preQ;
      always_ff @(posedge clk or negedge anyRstN) begin
        if (!anyRstN)                       preQ <= '0;
        else if (strb.start || strb.refresh) preQ <= '0;
        else if (running)                    preQ <= tick ? '0 : preQ + 1'b1;
      end
      assign tick = running && (preQ == PRE_W'(TICK_DIV - 1));
    end else begin : g_nopre
      assign tick = running;
    end
  endgenerate

  assign expire = tick && (cntQ == CNT_ONE) && !strb.refresh && !strb.stop;

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN)                cntQ <= CNT_MAX;
    else if (strb.refresh)       cntQ <= reloadQ;
    else if (strb.start)         cntQ <= (cntQ == '0) ? reloadQ : cntQ;
    else if (tick && !strb.stop) cntQ <= cntQ - 1'b1;
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN)        reloadQ <= CNT_MAX;
    else if (strb.cntWr) reloadQ <= (wrVal == '0) ? CNT_ONE : wrVal;
  end

  assign cntVal = cntQ;

  assert_reload_nonzero_R7: assert property (@(posedge clk) disable iff (!anyRstN)
    reloadQ != '0);
  assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!anyRstN)
    (!running && !strb.start) |=> $stable(cntQ));
  assert_step_by_one_R8: assert property (@(posedge clk) disable iff (!anyRstN)
    (tick && cntQ > CNT_ONE && !strb.refresh && !strb.stop) |=> (cntQ + 1'b1 == $past(cntQ)));
  assert_zero_after_expire_R9: assert property (@(posedge clk) disable iff (!anyRstN)
    expire |=> (cntQ == '0));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int COUNT_W   = 16,
  parameter int CTRL_OFS  = 0,
  parameter int COUNT_OFS = 4
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRstN,
  input  logic               hwEnable,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic [COUNT_W-1:0] cntVal,
  input  logic               expire,
  output wdStrobe_t          strb,
  output logic               runQ,
  output logic [DATA_W-1:0]  busRdData,
  output logic               rstReq,
  output logic               pwrOffReq
);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] COUNT_A = ADDR_W'(COUNT_OFS);

  logic anyRstN;
  logic ctrlWr;
  logic wantRun;
  logic wantTrig;
  logic firedQ;
  logic actionQ;
  logic rstReqQ;
  logic pwrOffQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [DATA_W-1:0] ctrlWord;
  logic unusedWrBits;

  assign anyRstN  = porRstN & sysRstN;
  assign ctrlWr   = busWrEn && (busAddr == CTRL_A);
  assign wantRun  = busWrData[RUN_BIT];
  assign wantTrig = busWrData[TRIG_BIT];
  assign unusedWrBits = ^{busWrData[DATA_W-1:TRIG_BIT+1], busWrData[DIS_BIT]};

  assign strb.start   = ctrlWr && wantRun && !runQ && hwEnable;
  assign strb.refresh = ctrlWr && wantRun && wantTrig && runQ && hwEnable;
  assign strb.stop    = ctrlWr && !wantRun && runQ;
  assign strb.cntWr   = busWrEn && (busAddr == COUNT_A);

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN)      runQ <= 1'b0;
    else if (!hwEnable) runQ <= 1'b0;
    else if (expire)   runQ <= 1'b0;
    else if (ctrlWr)   runQ <= wantRun;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      firedQ  <= 1'b0;
      actionQ <= 1'b1;
    end else begin
      if (expire)                                firedQ <= 1'b1;
      else if (ctrlWr && busWrData[FIRED_BIT])   firedQ <= 1'b0;
      if (ctrlWr) actionQ <= busWrData[ACT_BIT];
    end
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      rstReqQ <= 1'b0;
      pwrOffQ <= 1'b0;
    end else begin
      rstReqQ <= expire && actionQ;
      pwrOffQ <= expire && !actionQ;
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[RUN_BIT]   = runQ;
    ctrlWord[FIRED_BIT] = firedQ;
    ctrlWord[ACT_BIT]   = actionQ;
    ctrlWord[DIS_BIT]   = !hwEnable;
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) rdDataQ <= '0;
    else if (busRdEn) begin
      if (busAddr == CTRL_A)       rdDataQ <= ctrlWord;
      else if (busAddr == COUNT_A) rdDataQ <= {{(DATA_W-COUNT_W){1'b0}}, cntVal};
      else                         rdDataQ <= '0;
    end
  end

  assign busRdData = rdDataQ;
  assign rstReq    = rstReqQ;
  assign pwrOffReq = pwrOffQ;

  assert_disabled_no_run_R12: assert property (@(posedge clk) disable iff (!anyRstN)
    !hwEnable |=> !runQ);
  assert_expire_marks_fired_R9: assert property (@(posedge clk) disable iff (!anyRstN)
    expire |=> (firedQ && !runQ));
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!anyRstN)
    (rstReqQ || pwrOffQ) |=> !(rstReqQ || pwrOffQ));
  assert_one_action_R9: assert property (@(posedge clk) disable iff (!anyRstN)
    !(rstReqQ && pwrOffQ));
  assert_no_request_disabled_R12: assert property (@(posedge clk) disable iff (!anyRstN)
    !hwEnable |=> !(rstReqQ || pwrOffQ));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int COUNT_W   = 16,
  parameter int TICK_DIV  = 125_000_000,
  parameter int CTRL_OFS  = 0,
  parameter int COUNT_OFS = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              hwEnable,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              rstReq,
  output logic              pwrOffReq
);
  wdStrobe_t          strb;
  logic               runQ;
  logic               expire;
  logic [COUNT_W-1:0] cntVal;

  wdog_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W),
    .CTRL_OFS(CTRL_OFS), .COUNT_OFS(COUNT_OFS)
  ) u_ctrl (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .hwEnable(hwEnable),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .cntVal(cntVal), .expire(expire), .strb(strb), .runQ(runQ),
    .busRdData(busRdData), .rstReq(rstReq), .pwrOffReq(pwrOffReq)
  );

  wdog_datapath #(
    .COUNT_W(COUNT_W), .TICK_DIV(TICK_DIV)
  ) u_dp (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .hwEnable(hwEnable),
    .runQ(runQ), .strb(strb), .wrVal(busWrData[COUNT_W-1:0]),
    .cntVal(cntVal), .expire(expire)
  );
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic sysRstN = 1'b1;
  logic hwEnable = 1'b1;
  logic [3:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic rstReq, pwrOffReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  wdog_timer #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .hwEnable(hwEnable),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .rstReq(rstReq), .pwrOffReq(pwrOffReq)
  );

  // Behavioural reference model
  int mRun = 0, mFired = 0, mAction = 1, mReload = 'hFFFF, mCnt = 'hFFFF, mPre = 0;
  int mRst = 0, mPwr = 0;
  logic [31:0] mRd = '0;

  always @(posedge clk) begin
    if (!porRstN) begin
      mRun = 0; mFired = 0; mAction = 1; mReload = 'hFFFF; mCnt = 'hFFFF;
      mPre = 0; mRst = 0; mPwr = 0; mRd = '0;
    end else if (!sysRstN) begin
      mRun = 0; mReload = 'hFFFF; mCnt = 'hFFFF; mPre = 0; mRst = 0; mPwr = 0; mRd = '0;
    end else begin
      bit isCtrl, isCnt, wRun, wTrig, st, rf, sp, tk, ex, live;
      isCtrl = busWrEn && busAddr == 4'h0;
      isCnt  = busWrEn && busAddr == 4'h4;
      wRun = busWrData[0]; wTrig = busWrData[4];
      live = (mRun != 0) && hwEnable;
      st = isCtrl && wRun && mRun == 0 && hwEnable;
      rf = isCtrl && wRun && wTrig && live;
      sp = isCtrl && !wRun && mRun != 0;
      tk = live && mPre == DIV - 1;
      ex = tk && mCnt == 1 && !rf && !sp;
      if (busRdEn) begin
        if (busAddr == 4'h0) mRd = {28'd0, !hwEnable, mAction[0], mFired[0], mRun[0]};
        else if (busAddr == 4'h4) mRd = mCnt;
        else mRd = '0;
      end
      mRst = (ex && mAction != 0) ? 1 : 0;
      mPwr = (ex && mAction == 0) ? 1 : 0;
      if (st || rf) mPre = 0;
      else if (live) mPre = tk ? 0 : mPre + 1;
      if (rf) mCnt = mReload;
      else if (st) mCnt = (mCnt == 0) ? mReload : mCnt;
      else if (tk && !sp) mCnt = mCnt - 1;
      if (isCnt) mReload = (busWrData[15:0] == 0) ? 1 : int'(busWrData[15:0]);
      if (ex) mFired = 1;
      else if (isCtrl && busWrData[1]) mFired = 0;
      if (!hwEnable || ex) mRun = 0;
      else if (isCtrl) mRun = wRun;
      if (isCtrl) mAction = busWrData[2];
    end
  end

  always @(negedge clk) begin
    if (porRstN && sysRstN) begin
      checks += 3;
      if (rstReq !== mRst[0]) begin
        errors++; $display("FAIL %s model rstReq act=%0b exp=%0b", curReq, rstReq, mRst[0]);
      end
      if (pwrOffReq !== mPwr[0]) begin
        errors++; $display("FAIL %s model pwrOffReq act=%0b exp=%0b", curReq, pwrOffReq, mPwr[0]);
      end
      if (busRdData !== mRd) begin
        errors++; $display("FAIL %s model rdData act=%h exp=%h", curReq, busRdData, mRd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic watch(input int maxC, output int rAt, output int rW, output int pAt, output int pW);
    rAt = -1; rW = 0; pAt = -1; pW = 0;
    for (int i = 1; i <= maxC; i++) begin
      @(negedge clk);
      if (rstReq) begin if (rAt < 0) rAt = i; rW++; end
      if (pwrOffReq) begin if (pAt < 0) pAt = i; pW++; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog timeout act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, held;
    int rAt, rW, pAt, pW;
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);

    curReq = "R1";
    rd(4'h0, d); chk("R1 ctrl after por", d, 32'h4);
    rd(4'h4, d); chk("R1 count after por", d, 32'hFFFF);
    chk("R1 no requests", {30'd0, rstReq, pwrOffReq}, 32'h0);
    curReq = "R2";
    rd(4'h8, d); chk("R2 unmapped reads 0", d, 32'h0);
    wr(4'hC, 32'h1); rd(4'h0, d); chk("R2 unmapped write ignored", d, 32'h4);

    curReq = "R7";
    wr(4'h4, 32'hABCD_000A);
    rd(4'h4, d); chk("R7 count read is counter not reload", d, 32'hFFFF);

    curReq = "R4";
    wr(4'h0, 32'h15);
    rd(4'h4, d); chk("R4 start+trigger keeps held count", d, 32'hFFFF);
    rd(4'h0, d); chk("R2 trigger reads 0, run set", d, 32'h5);

    curReq = "R5";
    wr(4'h0, 32'h15);
    rd(4'h4, d); chk("R5 refresh loads reload", d, 32'd10);
    curReq = "R8";
    repeat (6) @(negedge clk);
    rd(4'h4, d); chk("R8 one tick after DIV cycles", d, 32'd9);

    curReq = "R6";
    wr(4'h0, 32'h4);
    rd(4'h4, held);
    repeat (10) @(negedge clk);
    rd(4'h4, d); chk("R6 counter holds when stopped", d, held);
    rd(4'h0, d); chk("R6 run cleared", d, 32'h4);

    curReq = "R3";
    wr(4'h0, 32'h15);
    rd(4'h4, d); chk("R3 restart resumes held count", d, held);

    curReq = "R9";
    wr(4'h4, 32'd2);
    wr(4'h0, 32'h15);
    watch(20, rAt, rW, pAt, pW);
    chk("R9 reset request cycle", rAt, 32'd8);
    chk("R9 reset request width", rW, 32'd1);
    chk("R9 no power-off request", pW, 32'd0);
    rd(4'h0, d); chk("R9 fired set, run clear", d, 32'h6);
    rd(4'h4, d); chk("R9 counter held at zero", d, 32'h0);

    curReq = "R10";
    wr(4'h0, 32'h6);
    rd(4'h0, d); chk("R10 fired write-1-clear", d, 32'h4);

    curReq = "R7";
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h1);
    watch(12, rAt, rW, pAt, pW);
    chk("R7 zero reload acts as one tick", pAt, 32'd4);
    chk("R9 power-off width", pW, 32'd1);
    chk("R9 no reset request", rW, 32'd0);
    rd(4'h0, d); chk("R9 fired with action 0", d, 32'h2);

    curReq = "R10";
    @(negedge clk); sysRstN = 1'b0;
    repeat (3) @(negedge clk); sysRstN = 1'b1;
    @(negedge clk);
    rd(4'h0, d); chk("R10 fired and action survive system reset", d, 32'h2);
    curReq = "R11";
    rd(4'h4, d); chk("R11 counter reset to max", d, 32'hFFFF);
    wr(4'h0, 32'h1);
    wr(4'h0, 32'h11);
    rd(4'h4, d); chk("R11 reload reset to max", d, 32'hFFFF);
    wr(4'h0, 32'h0);

    curReq = "R10";
    porRstN = 1'b0;
    repeat (3) @(negedge clk); porRstN = 1'b1;
    @(negedge clk);
    rd(4'h0, d); chk("R10 power-on reset clears fired, sets action", d, 32'h4);

    curReq = "R12";
    hwEnable = 1'b0;
    rd(4'h0, d); chk("R12 disabled bit", d, 32'hC);
    wr(4'h4, 32'h1);
    wr(4'h0, 32'h15);
    rd(4'h0, d); chk("R12 start refused when disabled", d, 32'hC);
    watch(20, rAt, rW, pAt, pW);
    chk("R12 no requests when disabled", rW + pW, 32'd0);
    rd(4'h4, d); chk("R12 no ticks when disabled", d, 32'hFFFF);
    hwEnable = 1'b1;
    wr(4'h0, 32'h5);
    rd(4'h0, d); chk("R12 runs once enabled", d, 32'h5);
    hwEnable = 1'b0;
    @(negedge clk);
    rd(4'h0, d); chk("R12 disable clears run", d, 32'hC);

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule